// File: doc/BRIEF.md
# Serial Control Register Slave for a Clock Generator

This block is the serial control port of a clock-generator chip. It listens on a two-wire SMBus-style bus and holds the control register file. The clock-gating and output logic elsewhere on the chip reads that register file. SCL and SDA arrive as plain inputs and are sampled by a fast system clock. The slave pulls SDA low through a single output-enable pin, and the pad turns that into an open-drain driver.

A write carries four kinds of byte in order. The first is the device address. The second is a command byte, whose value is ignored. The third is a count byte, whose value is also ignored. After that come the data bytes, and these always fill the registers from index 0 upward. A read sends the address and then receives the registers, again from index 0 upward, until the master answers a byte with a not-acknowledge.

Some register bits do not hold stored data. They show the live levels of input pins, or they combine a stored bit with a pin level. One register is a fixed identification value.

Top module: `smb_ctrl_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). After any other address it acknowledges nothing and changes no register until the next START.
- R2: In a write, the slave acknowledges the command byte and the count byte that follow the address. Neither value changes what is stored or where storing begins.
- R3: Each data byte of a write goes to the next register, starting at index 0 in every transaction. Only the writable bits are updated. Writable masks: reg0 0xE8, reg1 0x7F, reg6 0x00, and 0xFF for regs 2-5 and 7-9.
- R4: Register 0 shows live pin levels. Bit 4 is the host-halt pin, and bits 2..0 are the frequency-select pins, with select bit 2 in bit 2. Register 1 bit 7 is the drive-multiplier pin. Writes do not alter any of these bits.
- R5: Register 0 bit 3 reads as the stored bit ANDed with the bus-halt pin. The stored bit resets to 1.
- R6: Register 6 always reads 0x03. A data byte sent to it is acknowledged and discarded.
- R7: After reset, the stored contents are: reg0 0x08 (writable part), reg1 0x07 (writable part), reg2 0x7F, reg3 0xC7, reg4 0x3F, reg5 0x40, and reg7-reg9 0x00.
- R8: Write data sent past the last register (index 9) is acknowledged and dropped. Read bytes past the last register return 0x00.
- R9: A read returns register 0, then 1, and so on, one byte per master acknowledge. After a master not-acknowledge the slave releases SDA.
- R10: The slave pulls SDA low only during its own acknowledge bits and during the zero bits of read data. It never starts pulling while SCL is high.
- R11: A STOP releases SDA and ends the transaction. The next transaction starts again at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| host_halt_n_i | input | 1 | Host clock halt pin, shown in reg0 bit 4 |
| bus_halt_n_i | input | 1 | Bus clock halt pin, ANDed into reg0 bit 3 |
| freq_sel_i | input | 3 | Frequency select pins, shown in reg0 bits 2..0 |
| drive_mult_i | input | 1 | Drive-multiplier pin, shown in reg1 bit 7 |
| ctrl_image | output | 80 | Read view of all registers; register i is in bits 8i+7..8i |

## Verification
Two things can happen in the same stretch of time. A bus write can store the bit that feeds the bus-halt AND while the external halt pin is changing. The bench provokes this by dropping the pin between the count byte and the data byte of a write that sets that bit. It then checks that the combined bit reads 0 while the pin is low and 1 once the pin returns high, and that the stored bit survived. A pin-level sweep also runs while read transactions capture register 0. Each read byte is judged against the pin levels that held when it was sent.

// File: rtl/smb_pkg.sv
package smb_pkg;

   typedef enum logic [2:0] {
      L_IDLE,
      L_RX,
      L_ACK,
      L_TX,
      L_TXACK
   } link_st_t;

   typedef enum logic [1:0] {
      P_ADDR,
      P_CMD,
      P_CNT,
      P_DATA
   } byte_pos_t;

   // bits of each register that a bus write may change
   function automatic logic [7:0] reg_wmask(input int idx);
      case (idx)
         0:       return 8'hE8;
         1:       return 8'h7F;
         6:       return 8'h00;
         default: return 8'hFF;
      endcase
   endfunction

   // stored value after reset (fixed value for read-only registers)
   function automatic logic [7:0] reg_rstval(input int idx);
      case (idx)
         0:       return 8'h08;
         1:       return 8'h07;
         2:       return 8'h7F;
         3:       return 8'hC7;
         4:       return 8'h3F;
         5:       return 8'h40;
         6:       return 8'h03;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
   parameter int            W      = 1,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("smb_sync needs at least two stages");
   end

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg[k] <= INIT;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
   import smb_pkg::*;
#(
   parameter int NUM_REGS = 10,
   parameter int PTR_W    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [PTR_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   input  logic                  host_halt_n,
   input  logic                  bus_halt_n,
   input  logic [2:0]            freq_sel,
   input  logic                  drive_mult,
   output logic [NUM_REGS*8-1:0] image
);

   logic [7:0] view [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      localparam logic [7:0] WM = reg_wmask(i);
      localparam logic [7:0] RV = reg_rstval(i);
      logic [7:0] fixed_b;
      logic [7:0] gate_b;

      if (i == 0) begin : g_live0
         assign fixed_b = {3'b000, host_halt_n, 1'b0, freq_sel};
         assign gate_b  = {4'hF, bus_halt_n, 3'b111};
      end else if (i == 1) begin : g_live1
         assign fixed_b = {drive_mult, 7'b0};
         assign gate_b  = 8'hFF;
      end else begin : g_plain
         assign fixed_b = RV;
         assign gate_b  = 8'hFF;
      end

      if (WM == 8'h00) begin : g_ro
         assign view[i] = fixed_b & gate_b;
      end else begin : g_rw
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RV & WM;
            else if (wr_en && wr_idx == PTR_W'(i))
               q <= (q & ~WM) | (wr_data & WM);
         end
         assign view[i] = ((q & WM) | (fixed_b & ~WM)) & gate_b;
      end

      assign image[i*8 +: 8] = view[i];
   end

   always_comb begin
      rd_data = 8'h00;
      for (int k = 0; k < NUM_REGS; k++)
         if (rd_idx == PTR_W'(k)) rd_data = view[k];
   end

endmodule

// File: rtl/smb_link.sv
module smb_link
   import smb_pkg::*;
#(
   parameter int         NUM_REGS  = 10,
   parameter int         PTR_W     = 4,
   parameter logic [6:0] DEV_ADDR7 = 7'h69
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s,
   input  logic             sda_s,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [PTR_W-1:0] rd_idx,
   input  logic [7:0]       rd_data,
   output logic             sda_oe
);

   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

   link_st_t         state;
   byte_pos_t        pos;
   logic [3:0]       cnt;
   logic [7:0]       shreg;
   logic [7:0]       txreg;
   logic [PTR_W-1:0] ptr;
   logic             rd_mode;
   logic             nack;
   logic             scl_q, sda_q;

   logic scl_rise, scl_fall, start_ev, stop_ev;
   assign scl_rise = scl_s & ~scl_q;
   assign scl_fall = ~scl_s & scl_q;
   assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

   assign rd_idx = ptr;
   assign sda_oe = (state == L_ACK) || (state == L_TX && !txreg[7]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= L_IDLE;
         pos     <= P_ADDR;
         cnt     <= '0;
         shreg   <= '0;
         txreg   <= 8'hFF;
         ptr     <= '0;
         rd_mode <= 1'b0;
         nack    <= 1'b0;
         scl_q   <= 1'b1;
         sda_q   <= 1'b1;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         wr_en <= 1'b0;
         if (stop_ev) begin
            state <= L_IDLE;
         end else if (start_ev) begin
            state <= L_RX;
            pos   <= P_ADDR;
            cnt   <= '0;
         end else begin
            case (state)
               L_RX: begin
                  if (scl_rise && cnt < 4'd8) begin
                     shreg <= {shreg[6:0], sda_s};
                     cnt   <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     cnt <= '0;
                     case (pos)
                        P_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR7) begin
                              state   <= L_ACK;
                              rd_mode <= shreg[0];
                              ptr     <= '0;
                              pos     <= P_CMD;
                           end else begin
                              state <= L_IDLE;
                           end
                        end
                        P_CMD: begin
                           state <= L_ACK;
                           pos   <= P_CNT;
                        end
                        P_CNT: begin
                           state <= L_ACK;
                           pos   <= P_DATA;
                        end
                        default: begin
                           state <= L_ACK;
                           if (ptr < PTR_END) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= ptr;
                              wr_data <= shreg;
                              ptr     <= ptr + 1'b1;
                           end
                        end
                     endcase
                  end
               end
               L_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        state <= L_TX;
                        txreg <= rd_data;
                        cnt   <= '0;
                        if (ptr != PTR_END) ptr <= ptr + 1'b1;
                     end else begin
                        state <= L_RX;
                     end
                  end
               end
               L_TX: begin
                  if (scl_fall) begin
                     if (cnt == 4'd7) begin
                        state <= L_TXACK;
                        nack  <= 1'b0;
                     end else begin
                        txreg <= {txreg[6:0], 1'b0};
                        cnt   <= cnt + 4'd1;
                     end
                  end
               end
               L_TXACK: begin
                  if (scl_rise) begin
                     nack <= sda_s;
                  end else if (scl_fall) begin
                     if (nack) begin
                        state <= L_IDLE;
                     end else begin
                        state <= L_TX;
                        txreg <= rd_data;
                        cnt   <= '0;
                        if (ptr != PTR_END) ptr <= ptr + 1'b1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_ctrl_slave.sv
module smb_ctrl_slave
   import smb_pkg::*;
#(
   parameter int         NUM_REGS    = 10,
   parameter logic [6:0] DEV_ADDR7   = 7'h69,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   input  logic                  host_halt_n_i,
   input  logic                  bus_halt_n_i,
   input  logic [2:0]            freq_sel_i,
   input  logic                  drive_mult_i,
   output logic [NUM_REGS*8-1:0] ctrl_image
);

   localparam int PTR_W = $clog2(NUM_REGS + 1);

   if (NUM_REGS < 7 || NUM_REGS > 255) begin : g_bad_regs
      $error("NUM_REGS must lie between 7 and 255");
   end

   logic             scl_s, sda_s;
   logic [5:0]       pin_s;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx, rd_idx;
   logic [7:0]       wr_data, rd_data;

   smb_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     ({scl_s, sda_s})
   );

   smb_sync #(.W(6), .STAGES(SYNC_STAGES), .INIT(6'h3F)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({host_halt_n_i, bus_halt_n_i, freq_sel_i, drive_mult_i}),
      .q     (pin_s)
   );

   smb_link #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .DEV_ADDR7(DEV_ADDR7)) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_s   (scl_s),
      .sda_s   (sda_s),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (rd_idx),
      .rd_data (rd_data),
      .sda_oe  (sda_oe)
   );

   smb_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_data     (wr_data),
      .rd_idx      (rd_idx),
      .rd_data     (rd_data),
      .host_halt_n (pin_s[5]),
      .bus_halt_n  (pin_s[4]),
      .freq_sel    (pin_s[3:1]),
      .drive_mult  (pin_s[0]),
      .image       (ctrl_image)
   );

endmodule

// File: rtl/smb_ctrl_slave_chk.sv
module smb_ctrl_slave_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       sda_s,
   input logic       sda_oe,
   input logic [2:0] freq_sel,
   input logic [2:0] img_fsel,
   input logic [7:0] img_reg2
);

   logic [1:0] warm;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= 2'd0;
      else if (warm != 2'd3) warm <= warm + 2'd1;
   end

   // R3: a stored register changes only while the slave acknowledges a data byte
   a_r3_write_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(img_reg2) |-> sda_oe);

   // R10: the slave never begins pulling SDA while SCL is high
   a_r10_no_grab_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> !$rose(sda_oe));

   // R11: a STOP seen on the synchronized lines releases SDA on the next cycle
   a_r11_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && sda_s && !$past(sda_s)) |=> !sda_oe);

   if (SYNC_STAGES == 2) begin : g_live
      // R4: the select bits in register 0 follow the pins after two sync stages
      a_r4_live_fsel: assert property (@(posedge clk) disable iff (!rst_n)
         (warm == 2'd3) |-> (img_fsel == $past(freq_sel, 2)));
   end

endmodule

bind smb_ctrl_slave smb_ctrl_slave_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_s    (sda_s),
   .sda_oe   (sda_oe),
   .freq_sel (freq_sel_i),
   .img_fsel (ctrl_image[2:0]),
   .img_reg2 (ctrl_image[23:16])
);

// File: tb/smb_ctrl_slave_bench.sv
module smb_ctrl_slave_bench;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, scl_m, sda_m;
   logic        host_halt_n, bus_halt_n, drive_mult;
   logic [2:0]  freq_sel;
   logic        sda_oe;
   logic [79:0] image;
   logic        sda_line;

   assign sda_line = sda_m & ~sda_oe;

   smb_ctrl_slave u_smb_ctrl_slave (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_i         (scl_m),
      .sda_i         (sda_line),
      .sda_oe        (sda_oe),
      .host_halt_n_i (host_halt_n),
      .bus_halt_n_i  (bus_halt_n),
      .freq_sel_i    (freq_sel),
      .drive_mult_i  (drive_mult),
      .ctrl_image    (image)
   );

   int total = 0;
   int bad   = 0;
   int grab_hi = 0;
   logic oe_prev = 1'b0;
   logic [7:0] st   [10];
   logic [7:0] wbuf [16];
   logic [7:0] rbuf [16];

   // R10 monitor: a new pull on SDA must never start while SCL is high
   always @(negedge clk) begin
      if (scl_m && sda_oe && !oe_prev) grab_hi++;
      oe_prev <= sda_oe;
   end

   function automatic logic [7:0] wm(input int i);
      if (i == 0) return 8'hE8;
      if (i == 1) return 8'h7F;
      if (i == 6) return 8'h00;
      return 8'hFF;
   endfunction

   function automatic logic [7:0] exp_rd(input int i);
      if (i >= 10) return 8'h00;
      if (i == 0)  return {st[0][7:5], host_halt_n, st[0][3] & bus_halt_n, freq_sel};
      if (i == 1)  return {drive_mult, st[1][6:0]};
      if (i == 6)  return 8'h03;
      return st[i];
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic qw();
      repeat (8) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
      sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ackbit);
      for (int k = 7; k >= 0; k--) begin
         sda_m = b[k]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
      end
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
      ackbit = sda_line;
      qw(); scl_m = 1'b0; qw();
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int k = 7; k >= 0; k--) begin
         qw(); scl_m = 1'b1; qw();
         b[k] = sda_line;
         qw(); scl_m = 1'b0;
      end
      qw(); sda_m = ~give_ack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
      sda_m = 1'b1;
   endtask

   task automatic write_txn(input logic [7:0] addr, input int n, output int nacks);
      logic a;
      bus_start();
      wbyte(addr, a); nacks = int'(a);
      wbyte(8'h5A, a); nacks += int'(a);
      wbyte(8'(n), a); nacks += int'(a);
      for (int k = 0; k < n; k++) begin
         wbyte(wbuf[k], a); nacks += int'(a);
      end
      bus_stop();
   endtask

   task automatic read_txn(input logic [7:0] addr, input int n, output int nacks);
      logic a;
      bus_start();
      wbyte(addr, a); nacks = int'(a);
      if (!a)
         for (int k = 0; k < n; k++) rbyte(k < n - 1, rbuf[k]);
      bus_stop();
   endtask

   task automatic model_write(input int n);
      for (int k = 0; k < n && k < 10; k++)
         st[k] = (st[k] & ~wm(k)) | (wbuf[k] & wm(k));
   endtask

   task automatic check_image(input string tag);
      for (int i = 0; i < 10; i++) chk(tag, 32'(image[i*8 +: 8]), 32'(exp_rd(i)));
   endtask

   initial begin
      int nk;
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      host_halt_n = 1'b1; bus_halt_n = 1'b1; freq_sel = 3'b101; drive_mult = 1'b1;
      st[0] = 8'h08; st[1] = 8'h07; st[2] = 8'h7F; st[3] = 8'hC7; st[4] = 8'h3F;
      st[5] = 8'h40; st[6] = 8'h03; st[7] = 8'h00; st[8] = 8'h00; st[9] = 8'h00;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);

      // R7 reset contents, R10 bus released
      check_image("R7 reset image");
      chk("R10 idle release", 32'(sda_oe), 0);

      // R9/R8: read twelve bytes after reset
      read_txn(8'hD3, 12, nk);
      chk("R1 read address ack", 32'(nk), 0);
      for (int i = 0; i < 12; i++) chk("R9 R8 read after reset", 32'(rbuf[i]), 32'(exp_rd(i)));
      chk("R9 release after nack", 32'(sda_oe), 0);

      // R3/R2/R6/R8: pattern sweep over all registers plus two past the end
      for (int p = 0; p < 5; p++) begin
         for (int i = 0; i < 12; i++) begin
            case (p)
               0: wbuf[i] = 8'hFF;
               1: wbuf[i] = 8'h00;
               2: wbuf[i] = (i[0]) ? 8'h5A : 8'hA5;
               default: wbuf[i] = 8'((i * 37 + p * 11) & 255);
            endcase
         end
         write_txn(8'hD2, 12, nk);
         chk("R2 R8 all bytes acked", 32'(nk), 0);
         model_write(12);
         check_image("R3 image after write");
         chk("R6 signature kept", 32'(image[55:48]), 32'h03);
         read_txn(8'hD3, 12, nk);
         for (int i = 0; i < 12; i++) chk("R9 R8 readback", 32'(rbuf[i]), 32'(exp_rd(i)));
      end

      // R4/R5: sweep all pin levels, check image and bus read of regs 0 and 1
      for (int v = 0; v < 64; v++) begin
         host_halt_n = v[5]; bus_halt_n = v[4]; freq_sel = v[3:1]; drive_mult = v[0];
         repeat (6) @(negedge clk);
         chk("R4 R5 reg0 image", 32'(image[7:0]), 32'(exp_rd(0)));
         chk("R4 reg1 image", 32'(image[15:8]), 32'(exp_rd(1)));
         read_txn(8'hD3, 2, nk);
         chk("R4 R5 reg0 read", 32'(rbuf[0]), 32'(exp_rd(0)));
         chk("R4 reg1 read", 32'(rbuf[1]), 32'(exp_rd(1)));
      end
      host_halt_n = 1'b1; bus_halt_n = 1'b1; freq_sel = 3'b010; drive_mult = 1'b0;
      repeat (6) @(negedge clk);

      // R1: foreign addresses are ignored
      for (int i = 0; i < 4; i++) wbuf[i] = 8'h11 * (i + 1);
      write_txn(8'hA4, 4, nk);
      chk("R1 foreign write nacked", 32'(nk), 7);
      write_txn(8'hD0, 4, nk);
      chk("R1 near address nacked", 32'(nk), 7);
      check_image("R1 image unchanged");
      read_txn(8'hD5, 1, nk);
      chk("R1 foreign read nacked", 32'(nk), 1);

      // R11/R3: short write restarts at register 0, leaves reg1 untouched
      wbuf[0] = 8'h20;
      write_txn(8'hD2, 1, nk);
      model_write(1);
      chk("R11 short write acked", 32'(nk), 0);
      chk("R11 restart at reg0", 32'(image[7:0]), 32'(exp_rd(0)));
      chk("R11 reg1 untouched", 32'(image[15:8]), 32'(exp_rd(1)));
      chk("R11 release after stop", 32'(sda_oe), 0);

      // R5: halt pin drops during a write that sets the stored bit
      begin
         logic a;
         bus_start();
         wbyte(8'hD2, a); wbyte(8'hC3, a); wbyte(8'h01, a);
         bus_halt_n = 1'b0;
         wbyte(8'hE8, a);
         bus_stop();
         wbuf[0] = 8'hE8; model_write(1);
         repeat (6) @(negedge clk);
         chk("R5 bit3 with pin low", 32'(image[3]), 0);
         chk("R5 reg0 with pin low", 32'(image[7:0]), 32'(exp_rd(0)));
         bus_halt_n = 1'b1;
         repeat (6) @(negedge clk);
         chk("R5 bit3 with pin high", 32'(image[3]), 1);
      end

      chk("R10 no pull started while SCL high", 32'(grab_hi), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule